// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Decoder

This block holds the volatile position of a digitally controlled resistor ladder and turns it into the switch enables for the ladder's taps. The position is a 6-bit value. Position 0 connects the wiper to the low end of the ladder, and position 63 connects it to the high end. A registered decoder drives a 64-bit one-hot enable vector, so exactly one tap switch is closed at every moment.

The position can change in four ways:
- A host write loads a value directly.
- A transfer copies one of four stored settings, which arrive on a flat bank bus.
- A single-step strobe moves the wiper one tap up or down and saturates at both ends.
- A recall loads stored setting zero. The recall runs automatically on the first clock after reset, and it can also be requested with a strobe.

The position does not survive reset. It always restarts from whatever stored setting zero holds. Write protection of the stored settings belongs to the surrounding logic and has no path into this register.

Top module: `wiper_pos_reg`

## Requirements
- R1: `tap_o` always has exactly one bit set. Bit n is the enable for tap n: bit 0 is the low-end terminal and bit 63 is the high-end terminal. Once settled, the set bit's index equals `pos_o`.
- R2: `tap_o` follows a change of `pos_o` exactly one clock later.
- R3: While reset is asserted, `pos_o` is 0 and `tap_o` is 1. The first rising clock edge after reset is released loads `bank_i[5:0]` (stored setting zero) into `pos_o`.
- R4: A one-cycle pulse on `recall_i` loads `bank_i[5:0]` into `pos_o` on that clock edge, whatever other strobes are active.
- R5: A pulse on `host_wr_i` loads `host_val_i` into `pos_o` on that clock edge.
- R6: A pulse on `xfer_i` loads stored setting k into `pos_o`, where k is the value of `xfer_sel_i`. Setting k occupies `bank_i[6k+5:6k]`.
- R7: A pulse on `step_i` with `step_up_i`=1 adds one to `pos_o`. With `step_up_i`=0 it subtracts one.
- R8: A step up at position 63 and a step down at position 0 leave `pos_o` unchanged.
- R9: When several strobes arrive together, the order of precedence is: recall, then host write, then transfer, then step. A step that coincides with any load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| recall_i | input | 1 | Strobe: reload stored setting zero |
| host_wr_i | input | 1 | Strobe: load host value |
| host_val_i | input | 6 | Value for a host write |
| xfer_i | input | 1 | Strobe: load the selected stored setting |
| xfer_sel_i | input | 2 | Index of the stored setting to transfer |
| bank_i | input | 24 | Four stored settings, setting k at bits [6k+5:6k] |
| step_i | input | 1 | Strobe: move one tap |
| step_up_i | input | 1 | Step direction, 1 moves toward the high end |
| pos_o | output | 6 | Current wiper position |
| tap_o | output | 64 | One-hot tap switch enables |

## Verification
The assertions check the following on every cycle:
- the one-hot property of the tap vector, and that it tracks the position of the previous cycle;
- the result of each load path under its precedence;
- single steps and saturation at both ends.

Only the bench's scenarios can show the following:
- that the automatic recall happens once, on the first clock after reset, and uses the bank value present at that moment;
- that a recall strobe later in operation picks up a changed setting zero;
- that transfers reach each of the four bank slices with the correct bit placement.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    // Load source selected for the next position value
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RECALL = 2'd1,
        SRC_HOST   = 2'd2,
        SRC_XFER   = 2'd3
    } wpr_src_e;

endpackage

// File: rtl/wpr_src_mux.sv
module wpr_src_mux
    import wpr_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    parameter int SEL_W    = $clog2(NUM_BANK)
) (
    input  logic                      recall_i,
    input  logic                      host_wr_i,
    input  logic [POS_W-1:0]          host_val_i,
    input  logic                      xfer_i,
    input  logic [SEL_W-1:0]          xfer_sel_i,
    input  logic [NUM_BANK*POS_W-1:0] bank_i,
    output wpr_src_e                  src_o,
    output logic [POS_W-1:0]          val_o
);

    logic [POS_W-1:0] slot [NUM_BANK];

    for (genvar k = 0; k < NUM_BANK; k++) begin : g_slot
        assign slot[k] = bank_i[k*POS_W +: POS_W];
    end

    // Fixed precedence: recall, host write, transfer
    always_comb begin
        src_o = SRC_NONE;
        val_o = '0;
        if (recall_i) begin
            src_o = SRC_RECALL;
            val_o = slot[0];
        end else if (host_wr_i) begin
            src_o = SRC_HOST;
            val_o = host_val_i;
        end else if (xfer_i) begin
            src_o = SRC_XFER;
            val_o = slot[xfer_sel_i];
        end
    end

endmodule

// File: rtl/wpr_stepper.sv
module wpr_stepper #(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic             up_i,
    output logic [POS_W-1:0] pos_o
);

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] BOT = '0;

    // Saturating single step in either direction
    always_comb begin
        pos_o = pos_i;
        if (up_i) begin
            if (pos_i != TOP) pos_o = pos_i + POS_W'(1);
        end else begin
            if (pos_i != BOT) pos_o = pos_i - POS_W'(1);
        end
    end

endmodule

// File: rtl/wpr_tap_dec.sv
module wpr_tap_dec #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos_i,
    output logic [TAPS-1:0]  tap_o
);

    logic [TAPS-1:0] tap_d, tap_q;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_d[i] = (pos_i == POS_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= TAPS'(1);
        else        tap_q <= tap_d;
    end

    assign tap_o = tap_q;

endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wpr_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    localparam int SEL_W   = $clog2(NUM_BANK),
    localparam int TAPS    = 1 << POS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recall_i,
    input  logic                      host_wr_i,
    input  logic [POS_W-1:0]          host_val_i,
    input  logic                      xfer_i,
    input  logic [SEL_W-1:0]          xfer_sel_i,
    input  logic [NUM_BANK*POS_W-1:0] bank_i,
    input  logic                      step_i,
    input  logic                      step_up_i,
    output logic [POS_W-1:0]          pos_o,
    output logic [TAPS-1:0]           tap_o
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             pend;   // automatic recall still owed after reset
    } wpr_state_t;

    wpr_state_t       st_d, st_q;
    wpr_src_e         src;
    logic [POS_W-1:0] load_val;
    logic [POS_W-1:0] step_val;

    wpr_src_mux #(
        .POS_W   (POS_W),
        .NUM_BANK(NUM_BANK),
        .SEL_W   (SEL_W)
    ) u_mux (
        .recall_i  (recall_i | st_q.pend),
        .host_wr_i (host_wr_i),
        .host_val_i(host_val_i),
        .xfer_i    (xfer_i),
        .xfer_sel_i(xfer_sel_i),
        .bank_i    (bank_i),
        .src_o     (src),
        .val_o     (load_val)
    );

    wpr_stepper #(
        .POS_W(POS_W)
    ) u_step (
        .pos_i(st_q.pos),
        .up_i (step_up_i),
        .pos_o(step_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (src != SRC_NONE) begin
            st_d.pos = load_val;
        end else if (step_i) begin
            st_d.pos = step_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pos  <= '0;
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    wpr_tap_dec #(
        .POS_W(POS_W),
        .TAPS (TAPS)
    ) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .pos_i(st_q.pos),
        .tap_o(tap_o)
    );

    assign pos_o = st_q.pos;

endmodule

// File: rtl/wiper_pos_reg_checker.sv
module wiper_pos_reg_checker #(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    parameter int SEL_W    = 2,
    parameter int TAPS     = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      recall_i,
    input logic                      pend,
    input logic                      host_wr_i,
    input logic [POS_W-1:0]          host_val_i,
    input logic                      xfer_i,
    input logic [SEL_W-1:0]          xfer_sel_i,
    input logic [NUM_BANK*POS_W-1:0] bank_i,
    input logic                      step_i,
    input logic                      step_up_i,
    input logic [POS_W-1:0]          pos_o,
    input logic [TAPS-1:0]           tap_o
);

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic             any_rec;
    logic             any_load;
    logic [POS_W-1:0] xsel_val;

    assign any_rec  = recall_i | pend;
    assign any_load = any_rec | host_wr_i | xfer_i;
    assign xsel_val = bank_i[xfer_sel_i*POS_W +: POS_W];

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_o) == 1); // R1

    AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tap_o[$past(pos_o)]); // R2

    AST_RECALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        any_rec |=> pos_o == $past(bank_i[POS_W-1:0])); // R4

    AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && !any_rec) |=> pos_o == $past(host_val_i)); // R5

    AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !host_wr_i && !any_rec) |=> pos_o == $past(xsel_val)); // R6

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && step_up_i && !any_load && pos_o != TOP) |=> pos_o == $past(pos_o) + POS_W'(1)); // R7

    AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !step_up_i && !any_load && pos_o != '0) |=> pos_o == $past(pos_o) - POS_W'(1)); // R7

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && step_up_i && !any_load && pos_o == TOP) |=> pos_o == TOP); // R8

    AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !step_up_i && !any_load && pos_o == '0) |=> pos_o == '0); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !any_load) |=> $stable(pos_o)); // R9

endmodule

bind wiper_pos_reg wiper_pos_reg_checker #(
    .POS_W   (POS_W),
    .NUM_BANK(NUM_BANK),
    .SEL_W   (SEL_W),
    .TAPS    (TAPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .recall_i  (recall_i),
    .pend      (st_q.pend),
    .host_wr_i (host_wr_i),
    .host_val_i(host_val_i),
    .xfer_i    (xfer_i),
    .xfer_sel_i(xfer_sel_i),
    .bank_i    (bank_i),
    .step_i    (step_i),
    .step_up_i (step_up_i),
    .pos_o     (pos_o),
    .tap_o     (tap_o)
);

// File: tb/wiper_pos_reg_bench.sv
module wiper_pos_reg_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [5:0]  host_val_i = '0;
    logic        xfer_i = 1'b0;
    logic [1:0]  xfer_sel_i = '0;
    logic [5:0]  bank [4];
    logic [23:0] bank_i;
    logic        step_i = 1'b0;
    logic        step_up_i = 1'b0;
    logic [5:0]  pos_o;
    logic [63:0] tap_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    assign bank_i = {bank[3], bank[2], bank[1], bank[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_pos_reg u_wiper_pos_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .recall_i  (recall_i),
        .host_wr_i (host_wr_i),
        .host_val_i(host_val_i),
        .xfer_i    (xfer_i),
        .xfer_sel_i(xfer_sel_i),
        .bank_i    (bank_i),
        .step_i    (step_i),
        .step_up_i (step_up_i),
        .pos_o     (pos_o),
        .tap_o     (tap_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Position must already be exp_pos; tap follows after one more edge
    task automatic check_tap(input string req, input logic [5:0] exp_pos);
        @(negedge clk);
        check(req, tap_o, 64'd1 << exp_pos);
        check("R1", 64'($countones(tap_o)), 64'd1);
    endtask

    task automatic clear_strobes();
        recall_i  = 1'b0;
        host_wr_i = 1'b0;
        xfer_i    = 1'b0;
        step_i    = 1'b0;
    endtask

    // One edge with the current strobes, then sample the position
    task automatic pulse_and_check(input string req, input logic [5:0] exp_pos);
        @(negedge clk);
        clear_strobes();
        check(req, 64'(pos_o), 64'(exp_pos));
    endtask

    task automatic t_reset();
        bank[0] = 6'h2A; bank[1] = 6'h05; bank[2] = 6'h3F; bank[3] = 6'h11;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 reset pos", 64'(pos_o), 64'd0);
        check("R3 reset tap", tap_o, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 auto recall", 64'(pos_o), 64'h2A);
        check_tap("R2 tap after recall", 6'h2A);
        @(negedge clk);
        check("R3 recall only once", 64'(pos_o), 64'h2A);
    endtask

    task automatic t_host();
        host_val_i = 6'h13; host_wr_i = 1'b1;
        pulse_and_check("R5 host write", 6'h13);
        check_tap("R1 tap after host", 6'h13);
    endtask

    task automatic t_xfer();
        for (int k = 0; k < 4; k++) begin
            xfer_sel_i = 2'(k); xfer_i = 1'b1;
            pulse_and_check("R6 transfer", bank[k]);
            check_tap("R2 tap after transfer", bank[k]);
        end
    endtask

    task automatic t_step();
        host_val_i = 6'h20; host_wr_i = 1'b1;
        pulse_and_check("R5 preset", 6'h20);
        step_i = 1'b1; step_up_i = 1'b1;
        pulse_and_check("R7 step up", 6'h21);
        step_i = 1'b1; step_up_i = 1'b0;
        @(negedge clk);
        check("R7 step down 1", 64'(pos_o), 64'h20);
        pulse_and_check("R7 step down 2", 6'h1F);
        check_tap("R2 tap after steps", 6'h1F);
    endtask

    task automatic t_saturate();
        host_val_i = 6'h3F; host_wr_i = 1'b1;
        pulse_and_check("R5 preset top", 6'h3F);
        step_i = 1'b1; step_up_i = 1'b1;
        pulse_and_check("R8 saturate top", 6'h3F);
        check_tap("R8 tap at top", 6'h3F);
        host_val_i = 6'h00; host_wr_i = 1'b1;
        pulse_and_check("R5 preset bottom", 6'h00);
        step_i = 1'b1; step_up_i = 1'b0;
        pulse_and_check("R8 saturate bottom", 6'h00);
        check_tap("R8 tap at bottom", 6'h00);
    endtask

    task automatic t_priority();
        host_val_i = 6'h07; host_wr_i = 1'b1; step_i = 1'b1; step_up_i = 1'b1;
        pulse_and_check("R9 host over step", 6'h07);
        xfer_sel_i = 2'd3; xfer_i = 1'b1; step_i = 1'b1; step_up_i = 1'b0;
        pulse_and_check("R9 transfer over step", 6'h11);
        host_val_i = 6'h30; host_wr_i = 1'b1; xfer_sel_i = 2'd1; xfer_i = 1'b1;
        pulse_and_check("R9 host over transfer", 6'h30);
        recall_i = 1'b1; host_val_i = 6'h01; host_wr_i = 1'b1; xfer_i = 1'b1; step_i = 1'b1;
        pulse_and_check("R9 recall over all", 6'h2A);
    endtask

    task automatic t_recall();
        host_val_i = 6'h02; host_wr_i = 1'b1;
        pulse_and_check("R5 preset", 6'h02);
        bank[0] = 6'h19;
        @(negedge clk);
        check("R4 no recall without strobe", 64'(pos_o), 64'h02);
        recall_i = 1'b1;
        pulse_and_check("R4 recall strobe", 6'h19);
        check_tap("R2 tap after recall strobe", 6'h19);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_host();
        t_xfer();
        t_step();
        t_saturate();
        t_priority();
        t_recall();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule